// File: doc/BRIEF.md
# Periodic Remote Scan Sequencer

This block is the central side of a polled serial acquisition bus. A host fills a scan table that describes one complete major frame and then issues a start command. The block then takes one table entry per interval tick. For each entry it sends a two-byte command to the addressed remote node and waits for that node's reply. It checks the reply and writes the payload words into the current receive buffer. An entry flagged as the end of a minor frame closes the buffer. The block hands the closed buffer to the host through a pending bit and an interrupt, and then moves to the next free buffer. Scanning therefore carries on while the host drains earlier frames.

The interval between steps is programmable. A mode bit selects one of two period registers, one for the word-synchronous rate and one for the frame-synchronous rate. The reset values correspond to 80 us and 12.5 ms at a 250 MHz clock. Each node has a sticky timeout flag and a sticky error-frame flag. A global overrun flag records that an unread buffer was overwritten. A stop request lets the step in progress finish and then halts the block. The buffer state is kept for the next start.

Top module: `scan_sequencer`

## Requirements
- R1: After reset, `irq`, `tx_valid` and `buf_we` are low, and the control (address 0), status (address 4) and node status (address 5) registers all read zero.
- R2: No command is sent before a start. A start is a write to address 0 with bit 0 set, and it restarts the table at entry 0 and the buffer at word 0. Once started, the first byte of successive steps is offered exactly P cycles apart. P is the word period at address 1 when control bit 2 is 0.
- R3: With control bit 2 set, the step spacing P is taken from the frame period at address 2.
- R4: A table entry holds the node ID in bits [7:0], the word count N in [13:8], a major-frame-end flag in [14] and a minor-frame-end flag in [15]. A step sends the node ID byte and then the byte {2'b10, N}. Entries are taken in order, and the table returns to entry 0 after an entry flagged as major-frame end. While `tx_ready` is low, `tx_valid` and `tx_data` hold.
- R5: A reply is the node ID byte, then N words sent high byte first, then a 16-bit sum of those words sent high byte first. Each word goes to the next word of the current buffer, at address buffer*BUF_WORDS + word. The word count restarts at 0 for every minor frame.
- R6: Completing an entry flagged as minor-frame end sets that buffer's pending bit (status bit b) and the interrupt flag (status bit 16, driven on `irq`). Scanning then continues in the first buffer after it, in rotation, whose pending bit is clear. Status bits [15:8] show the current buffer.
- R7: If more than the timeout-register (address 3) number of cycles pass without a reply byte, the node's timeout flag is set (node status bit n). The remaining words of the step are written as 16'hDEAD, and the next entry proceeds normally.
- R8: A reply whose ID byte differs from the addressed node, or whose sum is wrong, sets that node's error flag (node status bit 16+n). Its words are still stored.
- R9: If every other buffer is pending when a minor frame ends, the overrun flag (status bit 17) is set. Scanning then reuses the next buffer in rotation, which is the oldest pending one, and that buffer's pending bit is cleared.
- R10: A write to address 0 with bit 1 set lets the current step complete and then halts the block. No further commands are sent, control bit 0 reads 0, and the current buffer is kept.
- R11: Writing ones to status bits [NBUF-1:0], 16 or 17, or to node status bits, clears those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, combinational on reg_addr |
| irq | output | 1 | Buffer-ready interrupt, level |
| tbl_addr | output | TW | Scan table read address |
| tbl_data | input | 16 | Scan table entry, same-cycle read |
| buf_we | output | 1 | Receive buffer write strobe |
| buf_addr | output | AW | Receive buffer word address |
| buf_wdata | output | 16 | Receive buffer write data |
| tx_valid | output | 1 | Command byte valid |
| tx_ready | input | 1 | Serial transmitter accepts byte |
| tx_data | output | 8 | Command byte |
| rx_valid | input | 1 | Reply byte strobe |
| rx_data | input | 8 | Reply byte |

## Verification
The hardest state to reach is buffer overrun. It needs every buffer pending at the moment a minor frame closes, and the rotation pointer must also have wrapped. The stimulus sets up a one-entry table in which every step closes a minor frame. It runs this at the frame-mode rate and releases no buffers, so the fourth step fills the last free buffer. The fifth step then lands in the oldest pending one. A simulated remote node answers every command, and it can be set per node to stay silent, send a bad sum or send a wrong ID, so that timeout and error-frame handling occur inside otherwise normal minor frames.

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
  parameter int NBUF             = 4,
  parameter int BUF_WORDS        = 64,
  parameter int NODES            = 8,
  parameter int TBL_DEPTH        = 16,
  parameter int WORD_PERIOD_RST  = 20000,
  parameter int FRAME_PERIOD_RST = 3125000,
  parameter int TIMEOUT_RST      = 1000,
  parameter logic [15:0] FILLER  = 16'hDEAD,
  localparam int BW = $clog2(NBUF),
  localparam int WW = $clog2(BUF_WORDS),
  localparam int TW = $clog2(TBL_DEPTH),
  localparam int NW = $clog2(NODES),
  localparam int AW = $clog2(NBUF * BUF_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic [TW-1:0] tbl_addr,
  input  logic [15:0]   tbl_data,
  output logic          buf_we,
  output logic [AW-1:0] buf_addr,
  output logic [15:0]   buf_wdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data
);

  typedef enum logic [3:0] {
    S_IDLE, S_TXN, S_TXC, S_RID, S_RHI, S_RLO, S_CHI, S_CLO, S_FILL, S_DONE
  } state_t;

  state_t          state;
  logic            running, mode, stop_req, irq_q, ovr, id_ok;
  logic [31:0]     word_per, frame_per, tmo_lim, tick_cnt, wait_cnt;
  logic [TW-1:0]   ent_ptr;
  logic [15:0]     ent, sum;
  logic [WW-1:0]   wptr;
  logic [BW-1:0]   cur, nxt;
  logic [NBUF-1:0] pend;
  logic [NODES-1:0] node_tmo, node_err;
  logic [7:0]      hi;
  logic [5:0]      cnt;
  logic            none_free;

  wire [31:0] period     = mode ? frame_per : word_per;
  wire        tick       = running && (tick_cnt + 32'd1 >= period);
  wire [5:0]  len        = ent[13:8];
  wire [15:0] word       = {hi, rx_data};
  wire        waiting    = state inside {S_RID, S_RHI, S_RLO, S_CHI, S_CLO};
  wire        tmo_hit    = waiting && !rx_valid && (wait_cnt >= tmo_lim);
  wire        done_minor = (state == S_DONE) && ent[15];
  wire        w_ctrl     = reg_we && (reg_addr == 3'd0);
  wire        w_stat     = reg_we && (reg_addr == 3'd4);
  wire        w_node     = reg_we && (reg_addr == 3'd5);
  wire [NODES-1:0] node_oh = NODES'(1) << ent[NW-1:0];
  wire [NBUF-1:0]  cur_oh  = NBUF'(1) << cur;
  wire [NBUF-1:0]  nxt_oh  = NBUF'(1) << nxt;
  wire        bad_frame  = (state == S_CLO) && rx_valid && (!id_ok || word != sum);

  assign irq       = irq_q;
  assign tbl_addr  = ent_ptr;
  assign tx_valid  = (state == S_TXN) || (state == S_TXC);
  assign tx_data   = (state == S_TXN) ? ent[7:0] : {2'b10, ent[13:8]};
  assign buf_we    = ((state == S_RLO) && rx_valid) || ((state == S_FILL) && (cnt < len));
  assign buf_wdata = (state == S_FILL) ? FILLER : word;
  assign buf_addr  = AW'(cur) * AW'(BUF_WORDS) + AW'(wptr);

  always_comb begin
    nxt = (cur == BW'(NBUF - 1)) ? '0 : cur + 1'b1;
    none_free = 1'b1;
    for (int i = NBUF - 1; i >= 1; i--) begin
      if (!pend[(int'(cur) + i) % NBUF]) begin
        nxt = BW'((int'(cur) + i) % NBUF);
        none_free = 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      3'd0: begin reg_rdata[0] = running; reg_rdata[2] = mode; end
      3'd1: reg_rdata = word_per;
      3'd2: reg_rdata = frame_per;
      3'd3: reg_rdata = tmo_lim;
      3'd4: begin
        reg_rdata[NBUF-1:0] = pend;
        reg_rdata[15:8]     = 8'(cur);
        reg_rdata[16]       = irq_q;
        reg_rdata[17]       = ovr;
      end
      3'd5: begin
        reg_rdata[NODES-1:0]  = node_tmo;
        reg_rdata[16 +: NODES] = node_err;
      end
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= '0;
      irq_q    <= 1'b0;
      ovr      <= 1'b0;
      node_tmo <= '0;
      node_err <= '0;
    end else begin
      pend     <= ((pend & ~(w_stat ? reg_wdata[NBUF-1:0] : '0)) | (done_minor ? cur_oh : '0))
                  & ~(done_minor ? nxt_oh : '0);
      irq_q    <= (irq_q & ~(w_stat && reg_wdata[16])) | done_minor;
      ovr      <= (ovr & ~(w_stat && reg_wdata[17])) | (done_minor && none_free);
      node_tmo <= (node_tmo & ~(w_node ? reg_wdata[NODES-1:0] : '0)) | (tmo_hit ? node_oh : '0);
      node_err <= (node_err & ~(w_node ? reg_wdata[16 +: NODES] : '0)) | (bad_frame ? node_oh : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      running   <= 1'b0;
      mode      <= 1'b0;
      stop_req  <= 1'b0;
      word_per  <= 32'(WORD_PERIOD_RST);
      frame_per <= 32'(FRAME_PERIOD_RST);
      tmo_lim   <= 32'(TIMEOUT_RST);
      tick_cnt  <= '0;
      wait_cnt  <= '0;
      ent_ptr   <= '0;
      ent       <= '0;
      wptr      <= '0;
      cur       <= '0;
      hi        <= '0;
      sum       <= '0;
      cnt       <= '0;
      id_ok     <= 1'b0;
    end else begin
      tick_cnt <= (!running || tick) ? '0 : tick_cnt + 32'd1;
      wait_cnt <= (!waiting || rx_valid) ? '0 : wait_cnt + 32'd1;

      case (state)
        S_IDLE: begin
          if (stop_req) begin
            running  <= 1'b0;
            stop_req <= 1'b0;
          end else if (tick) begin
            ent   <= tbl_data;
            state <= S_TXN;
          end
        end
        S_TXN: if (tx_ready) state <= S_TXC;
        S_TXC: if (tx_ready) begin
          sum   <= '0;
          cnt   <= '0;
          state <= S_RID;
        end
        S_RID: begin
          if (rx_valid) begin
            id_ok <= (rx_data == ent[7:0]);
            state <= (len == 6'd0) ? S_CHI : S_RHI;
          end else if (tmo_hit) state <= S_FILL;
        end
        S_RHI: begin
          if (rx_valid) begin
            hi    <= rx_data;
            state <= S_RLO;
          end else if (tmo_hit) state <= S_FILL;
        end
        S_RLO: begin
          if (rx_valid) begin
            sum   <= sum + word;
            cnt   <= cnt + 6'd1;
            wptr  <= wptr + 1'b1;
            state <= (cnt + 6'd1 == len) ? S_CHI : S_RHI;
          end else if (tmo_hit) state <= S_FILL;
        end
        S_CHI: begin
          if (rx_valid) begin
            hi    <= rx_data;
            state <= S_CLO;
          end else if (tmo_hit) state <= S_FILL;
        end
        S_CLO: begin
          if (rx_valid) state <= S_DONE;
          else if (tmo_hit) state <= S_FILL;
        end
        S_FILL: begin
          if (cnt < len) begin
            cnt  <= cnt + 6'd1;
            wptr <= wptr + 1'b1;
          end else state <= S_DONE;
        end
        S_DONE: begin
          ent_ptr <= ent[14] ? '0 : ent_ptr + 1'b1;
          if (ent[15]) begin
            cur  <= nxt;
            wptr <= '0;
          end
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase

      if (reg_we && reg_addr == 3'd1) word_per  <= reg_wdata;
      if (reg_we && reg_addr == 3'd2) frame_per <= reg_wdata;
      if (reg_we && reg_addr == 3'd3) tmo_lim   <= reg_wdata;
      if (w_ctrl) begin
        mode <= reg_wdata[2];
        if (reg_wdata[1]) stop_req <= 1'b1;
        if (reg_wdata[0]) begin
          running  <= 1'b1;
          stop_req <= 1'b0;
          tick_cnt <= '0;
          ent_ptr  <= '0;
          wptr     <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/scan_sequencer_checker.sv
module scan_sequencer_checker #(
  parameter int NBUF = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tx_valid,
  input logic            tx_ready,
  input logic [7:0]      tx_data,
  input logic            irq,
  input logic            buf_we,
  input logic            running,
  input logic [NBUF-1:0] pend,
  input logic            ovr
);

  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_irq_has_buffer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($countones(pend) > 0));

  assert_overrun_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> ($past($countones(pend)) >= NBUF - 1));

  assert_write_while_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> running);

  assert_silent_when_halted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !tx_valid);

endmodule

bind scan_sequencer scan_sequencer_checker #(.NBUF(NBUF)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .irq(irq), .buf_we(buf_we), .running(running),
  .pend(pend), .ovr(ovr)
);

// File: tb/scan_sequencer_test.sv
module scan_sequencer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [3:0]  tbl_addr;
  logic [15:0] tbl_data;
  logic        buf_we;
  logic [7:0]  buf_addr;
  logic [15:0] buf_wdata;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;

  always #2 clk = ~clk;

  scan_sequencer uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data)
  );

  logic [15:0] tbl [16];
  logic [15:0] mem [256];
  logic [15:0] lg  [64];
  logic [1:0]  nmode [8];
  int ln = 0, steps = 0, eidx = 0, last_t = -1, exp_period = 0, cyc = 0;
  int checks = 0, fails = 0;

  assign tbl_data = tbl[tbl_addr];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (buf_we) mem[buf_addr] <= buf_wdata;
  end

  function automatic logic [15:0] mk(input bit mn, input bit mj, input int n, input logic [7:0] node);
    return {mn, mj, 6'(n), node};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic get_tx(output logic [7:0] b, output int t);
    do @(negedge clk); while (!(tx_valid && tx_ready));
    b = tx_data; t = cyc;
  endtask

  task automatic send(input logic [7:0] b);
    repeat (2) @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic wait_irq();
    int n = 0;
    while (!irq && n < 5000) begin @(negedge clk); n++; end
    chk("R6 irq raised", {31'b0, irq}, 32'd1);
  endtask

  task automatic wait_steps(input int target);
    while (steps < target) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  // remote node model
  initial begin
    logic [7:0] nb, cb;
    logic [15:0] w, s;
    int t, t2, n;
    forever begin
      get_tx(nb, t);
      if (last_t >= 0) chk("R2 R3 step spacing", t - last_t, exp_period);
      last_t = t;
      chk("R4 node byte", {24'b0, nb}, {24'b0, tbl[eidx][7:0]});
      get_tx(cb, t2);
      chk("R4 command byte", {24'b0, cb}, {24'b0, 2'b10, tbl[eidx][13:8]});
      n = int'(tbl[eidx][13:8]);
      if (nmode[nb[2:0]] == 2'd1) begin
        for (int k = 0; k < n; k++) begin lg[ln] = 16'hDEAD; ln++; end
      end else begin
        send(nmode[nb[2:0]] == 2'd3 ? nb ^ 8'h01 : nb);
        s = '0;
        for (int k = 0; k < n; k++) begin
          w = 16'($urandom);
          send(w[15:8]); send(w[7:0]);
          lg[ln] = w; ln++;
          s = s + w;
        end
        if (nmode[nb[2:0]] == 2'd2) s = s ^ 16'h0001;
        send(s[15:8]); send(s[7:0]);
      end
      eidx = tbl[eidx][14] ? 0 : eidx + 1;
      steps++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int la [4];
    int s0;
    void'($urandom(32'd1357));
    for (int i = 0; i < 8; i++) nmode[i] = 2'd0;
    for (int i = 0; i < 16; i++) tbl[i] = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 0);
    chk("R1 buf_we", {31'b0, buf_we}, 0);
    rd(3'd0, v); chk("R1 control", v, 0);
    rd(3'd4, v); chk("R1 status", v, 0);
    rd(3'd5, v); chk("R1 node status", v, 0);

    // normal scanning, rotation and table wrap
    for (int i = 0; i < 4; i++) la[i] = 1 + int'($urandom % 4);
    tbl[0] = mk(0, 0, la[0], 8'd1);
    tbl[1] = mk(1, 0, la[1], 8'd2);
    tbl[2] = mk(0, 0, la[2], 8'd3);
    tbl[3] = mk(1, 1, la[3], 8'd4);
    wr(3'd1, 300);
    wr(3'd3, 40);
    repeat (400) @(negedge clk);
    chk("R2 no command before start", steps, 0);
    ln = 0; eidx = 0; last_t = -1; exp_period = 300;
    wr(3'd0, 32'h1);
    for (int m = 0; m < 4; m++) begin
      wait_irq();
      rd(3'd4, v);
      chk("R6 pending bit", {31'b0, v[m]}, 1);
      chk("R6 current buffer advanced", {24'b0, v[15:8]}, (m + 1) % 4);
      chk("R5 word count", ln, (m % 2 == 0) ? la[0] + la[1] : la[2] + la[3]);
      for (int k = 0; k < ln; k++) chk("R5 buffer word", mem[m * 64 + k], lg[k]);
      ln = 0;
      wr(3'd4, (32'd1 << m) | 32'h1_0000);
      rd(3'd4, v);
      chk("R11 pending cleared", {28'b0, v[3:0]}, 0);
      chk("R11 irq cleared", {31'b0, v[16]}, 0);
    end

    // stop during a step
    while (!tx_valid) @(negedge clk);
    s0 = steps;
    wr(3'd0, 32'h2);
    repeat (1000) @(negedge clk);
    chk("R10 halted after one step", steps, s0 + 1);
    rd(3'd0, v); chk("R10 running bit", {31'b0, v[0]}, 0);
    rd(3'd4, v); chk("R10 buffer kept", {24'b0, v[15:8]}, 0);
    chk("R10 step words", ln, la[0]);
    for (int k = 0; k < ln; k++) chk("R10 step data stored", mem[k], lg[k]);

    // timeout and error frames
    tbl[0] = mk(0, 0, 3, 8'd5);
    tbl[1] = mk(0, 0, 2, 8'd6);
    tbl[2] = mk(0, 0, 2, 8'd7);
    tbl[3] = mk(1, 1, 2, 8'd1);
    nmode[5] = 2'd1; nmode[6] = 2'd2; nmode[7] = 2'd3;
    ln = 0; eidx = 0; last_t = -1;
    wr(3'd0, 32'h1);
    wait_irq();
    chk("R7 words per minor", ln, 9);
    for (int k = 0; k < 3; k++) chk("R7 filler word", mem[k], 16'hDEAD);
    for (int k = 3; k < 9; k++) chk("R8 words kept", mem[k], lg[k]);
    rd(3'd5, v);
    chk("R7 timeout flags", {24'b0, v[7:0]}, 32'h20);
    chk("R8 error flags", {24'b0, v[23:16]}, 32'hC0);
    wr(3'd0, 32'h2);
    repeat (20) @(negedge clk);
    wr(3'd4, 32'h1_0001);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, v); chk("R11 node flags cleared", v, 0);

    // overrun in frame mode
    for (int i = 0; i < 8; i++) nmode[i] = 2'd0;
    tbl[0] = mk(1, 1, 1, 8'd1);
    wr(3'd2, 150);
    ln = 0; eidx = 0; last_t = -1; exp_period = 150;
    s0 = steps;
    wr(3'd0, 32'h5);
    wait_steps(s0 + 3);
    rd(3'd4, v); chk("R9 no overrun with a free buffer", {31'b0, v[17]}, 0);
    wait_steps(s0 + 4);
    rd(3'd4, v);
    chk("R9 overrun flag", {31'b0, v[17]}, 1);
    chk("R9 pending after reuse", {28'b0, v[3:0]}, 32'hD);
    chk("R9 reused buffer", {24'b0, v[15:8]}, 1);
    wait_steps(s0 + 5);
    chk("R9 oldest buffer overwritten", mem[64], lg[4]);
    chk("R9 last buffer data", mem[0], lg[3]);
    chk("R3 frame mode step data", mem[128], lg[1]);
    wr(3'd0, 32'h2);
    repeat (200) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule